// File: doc/BRIEF.md
# Planar Read Path with Colour Match

This block serves host reads from a display memory organised as four planes. Each memory location is one 32-bit word that holds one byte per plane. Every accepted host read fetches the whole word. The block then returns a single byte to the host, in one of two ways. In plane mode it returns the raw byte of one chosen plane. In match mode it returns eight bits at once, and each bit tells whether the four-plane colour of that pixel column equals a reference colour.

Each read also copies the fetched word into a hidden 32-bit latch. The host cannot read the latch. A companion write unit uses it as a second operand, through the `latch_word` port. Only a completed memory fetch changes the latch, and it keeps its value between reads.

Requests and responses are both valid/ready streams. A request is taken only when no response is held, or when the held response is being accepted in that same cycle. A response that is not accepted stays on `rsp_data`, unchanged, until `rsp_ready` is high. The memory has a one-cycle read latency. The control fields are sampled when a request is accepted.

Top module: `planar_read_unit`

## Requirements
- R1: After reset `rsp_valid` is 0, `mem_rd_en` is 0 and `latch_word` is 0.
- R2: `req_ready` is 1 exactly when `rsp_valid` is 0 or `rsp_ready` is 1. A request is accepted when `req_valid` and `req_ready` are both 1. In that cycle `mem_rd_en` is 1 and `mem_addr` equals `req_addr`. In any other cycle `mem_rd_en` is 0.
- R3: `rsp_valid` is 1 in the cycle after an accepted request. The memory word is taken from `mem_rdata` in that cycle.
- R4: When `cfg_cmp_mode` is 0, `rsp_data` is the byte of plane `cfg_plane_sel`. Plane p occupies bits [8p+7:8p] of the memory word.
- R5: When `cfg_cmp_mode` is 1, bit i of `rsp_data` is 1 only if every plane p with `cfg_color_care[p]`=1 has word bit 8p+i equal to `cfg_color_ref[p]`. Planes whose care bit is 0 take no part in the comparison.
- R6: In match mode with `cfg_color_care` = 0, `rsp_data` is 8'hFF for any memory word.
- R7: Every accepted read, in either mode, loads the full fetched word into `latch_word`. The new value is visible from the second clock edge after acceptance.
- R8: `latch_word` keeps its value in every cycle in which no fetched word arrives.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, both `rsp_valid` and `rsp_data` stay unchanged in the next cycle.
- R10: The control fields are sampled when a request is accepted. Changes to them afterwards do not alter that response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Word address of the read |
| cfg_cmp_mode | input | 1 | 0 = plane byte, 1 = colour match |
| cfg_plane_sel | input | 2 | Plane returned in plane mode |
| cfg_color_ref | input | 4 | Reference colour, one bit per plane |
| cfg_color_care | input | 4 | Per-plane compare enable |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 32 | Memory word, valid one cycle after the strobe |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_data | output | 8 | Response byte |
| latch_word | output | 32 | Latched word for the write unit |

## Verification
The assertions check the following on every cycle:
- the handshake rules;
- the response appearing one cycle after acceptance;
- a stalled response holding steady;
- the latch loading the fetched word and otherwise staying put;
- the all-ones result when no plane takes part in the comparison.

Only the bench scenarios can show that the returned values are correct. They sweep every plane select and every reference/care combination against known memory words. They also change the controls during stalls and observe the latch after idle gaps.

// File: rtl/planar_rd_pkg.sv
package planar_rd_pkg;
  typedef enum logic {
    RD_PLANE = 1'b0,
    RD_MATCH = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/planar_rd_ctrl.sv
module planar_rd_ctrl
  import planar_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PLANES = 4,
  localparam int SEL_W = $clog2(PLANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_cmp_mode,
  input  logic [SEL_W-1:0]  cfg_plane_sel,
  input  logic [PLANES-1:0] cfg_color_ref,
  input  logic [PLANES-1:0] cfg_color_care,
  input  logic              rsp_ready,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rsp_valid,
  output logic              fresh,
  output rd_mode_e          mode_q,
  output logic [SEL_W-1:0]  sel_q,
  output logic [PLANES-1:0] ref_q,
  output logic [PLANES-1:0] care_q
);
  logic accept;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign mem_rd_en = accept;
  assign mem_addr  = req_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      fresh     <= 1'b0;
      mode_q    <= RD_PLANE;
      sel_q     <= '0;
      ref_q     <= '0;
      care_q    <= '0;
    end else begin
      rsp_valid <= accept || (rsp_valid && !rsp_ready);
      fresh     <= accept;
      if (accept) begin
        mode_q <= rd_mode_e'(cfg_cmp_mode);
        sel_q  <= cfg_plane_sel;
        ref_q  <= cfg_color_ref;
        care_q <= cfg_color_care;
      end
    end
  end

  // R3: response follows an accepted request
  p_rsp_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_valid && fresh));

  // R9: stalled response stays valid
  p_stall_keeps_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid);

  // R2: no strobe while a response is stuck
  p_no_read_in_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !mem_rd_en);

  // R10: captured controls frozen while response waits
  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> ($stable(mode_q) && $stable(sel_q) &&
                                    $stable(ref_q) && $stable(care_q)));
endmodule

// File: rtl/planar_latch.sv
module planar_latch #(
  parameter int PIX_W  = 8,
  parameter int PLANES = 4,
  localparam int WORD_W = PIX_W * PLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] d,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/planar_plane_sel.sv
module planar_plane_sel #(
  parameter int PIX_W  = 8,
  parameter int PLANES = 4,
  localparam int SEL_W  = $clog2(PLANES),
  localparam int WORD_W = PIX_W * PLANES
) (
  input  logic [WORD_W-1:0] word,
  input  logic [SEL_W-1:0]  sel,
  output logic [PIX_W-1:0]  byte_out
);
  logic [PIX_W-1:0] lanes [PLANES];

  for (genvar p = 0; p < PLANES; p++) begin : g_lane
    assign lanes[p] = word[p*PIX_W +: PIX_W];
  end

  always_comb begin
    byte_out = '0;
    for (int p = 0; p < PLANES; p++) begin
      if (sel == SEL_W'(p)) byte_out = lanes[p];
    end
  end
endmodule

// File: rtl/planar_color_cmp.sv
module planar_color_cmp #(
  parameter int PIX_W  = 8,
  parameter int PLANES = 4,
  localparam int WORD_W = PIX_W * PLANES
) (
  input  logic [WORD_W-1:0] word,
  input  logic [PLANES-1:0] ref_color,
  input  logic [PLANES-1:0] care,
  output logic [PIX_W-1:0]  match
);
  for (genvar i = 0; i < PIX_W; i++) begin : g_pix
    logic [PLANES-1:0] plane_ok;
    for (genvar p = 0; p < PLANES; p++) begin : g_pl
      assign plane_ok[p] = !care[p] || (word[p*PIX_W + i] == ref_color[p]);
    end
    assign match[i] = &plane_ok;
  end
endmodule

// File: rtl/planar_read_unit.sv
module planar_read_unit
  import planar_rd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PIX_W  = 8,
  parameter int PLANES = 4,
  localparam int SEL_W  = $clog2(PLANES),
  localparam int WORD_W = PIX_W * PLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_cmp_mode,
  input  logic [SEL_W-1:0]  cfg_plane_sel,
  input  logic [PLANES-1:0] cfg_color_ref,
  input  logic [PLANES-1:0] cfg_color_care,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PIX_W-1:0]  rsp_data,
  output logic [WORD_W-1:0] latch_word
);
  logic              fresh;
  rd_mode_e          mode_q;
  logic [SEL_W-1:0]  sel_q;
  logic [PLANES-1:0] ref_q;
  logic [PLANES-1:0] care_q;
  logic [WORD_W-1:0] word_src;
  logic [PIX_W-1:0]  plane_byte;
  logic [PIX_W-1:0]  match_byte;

  planar_rd_ctrl #(.ADDR_W(ADDR_W), .PLANES(PLANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .cfg_cmp_mode(cfg_cmp_mode), .cfg_plane_sel(cfg_plane_sel),
    .cfg_color_ref(cfg_color_ref), .cfg_color_care(cfg_color_care),
    .rsp_ready(rsp_ready), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .rsp_valid(rsp_valid), .fresh(fresh), .mode_q(mode_q),
    .sel_q(sel_q), .ref_q(ref_q), .care_q(care_q)
  );

  planar_latch #(.PIX_W(PIX_W), .PLANES(PLANES)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(fresh), .d(mem_rdata), .q(latch_word)
  );

  // live memory word in the first response cycle, latched copy while stalled
  assign word_src = fresh ? mem_rdata : latch_word;

  planar_plane_sel #(.PIX_W(PIX_W), .PLANES(PLANES)) u_sel (
    .word(word_src), .sel(sel_q), .byte_out(plane_byte)
  );

  planar_color_cmp #(.PIX_W(PIX_W), .PLANES(PLANES)) u_cmp (
    .word(word_src), .ref_color(ref_q), .care(care_q), .match(match_byte)
  );

  assign rsp_data = (mode_q == RD_MATCH) ? match_byte : plane_byte;

  // R9: stalled byte unchanged
  p_stall_data_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(rsp_data));

  // R7: fetched word lands in the latch
  p_latch_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> ##1 (latch_word == $past(mem_rdata)));

  // R8: latch idle without a fetch
  p_latch_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd_en |=> ##1 $stable(latch_word));

  // R6: nothing compared gives all ones
  p_no_care_all_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && mode_q == RD_MATCH && care_q == '0) |-> (rsp_data == '1));
endmodule

// File: tb/planar_read_unit_bench.sv
`timescale 1ns/1ps
module planar_read_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        cfg_cmp_mode = 1'b0;
  logic [1:0]  cfg_plane_sel = '0;
  logic [3:0]  cfg_color_ref = '0;
  logic [3:0]  cfg_color_care = '0;
  logic        mem_rd_en;
  logic [15:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_data;
  logic [31:0] latch_word;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  planar_read_unit u_planar_read_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .cfg_cmp_mode(cfg_cmp_mode), .cfg_plane_sel(cfg_plane_sel),
    .cfg_color_ref(cfg_color_ref), .cfg_color_care(cfg_color_care),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .latch_word(latch_word)
  );

  function automatic logic [31:0] word_of(input logic [15:0] a);
    return (32'(a) * 32'h9E3779B9) ^ 32'h5A3C0F96;
  endfunction

  // memory model: one-cycle registered read
  always @(posedge clk) if (mem_rd_en) mem_rdata <= word_of(mem_addr);

  function automatic logic [7:0] exp_match(input logic [31:0] w,
                                           input logic [3:0] r, input logic [3:0] c);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) begin
      m[i] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (c[p] && (w[8*p+i] != r[p])) m[i] = 1'b0;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input logic mode, input logic [1:0] sel,
                         input logic [3:0] r, input logic [3:0] c, input int stall);
    logic [31:0] w;
    logic [7:0]  e;
    w = word_of(a);
    e = mode ? exp_match(w, r, c) : w[8*sel +: 8];
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; cfg_cmp_mode = mode;
    cfg_plane_sel = sel; cfg_color_ref = r; cfg_color_care = c;
    rsp_ready = (stall == 0);
    #1;
    check("R2 req_ready", 32'(req_ready), 1);
    check("R2 mem_rd_en", 32'(mem_rd_en), 1);
    check("R2 mem_addr", 32'(mem_addr), 32'(a));
    @(negedge clk);
    req_valid = 1'b0;
    cfg_cmp_mode = ~mode; cfg_plane_sel = sel + 2'd1;   // R10: late changes
    cfg_color_ref = ~r; cfg_color_care = ~c;
    #1;
    check("R3 rsp_valid", 32'(rsp_valid), 1);
    check(mode ? "R5 match byte" : "R4 plane byte", 32'(rsp_data), 32'(e));
    if (mode && c == 4'd0) check("R6 all ones", 32'(rsp_data), 32'hFF);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R9 stalled valid", 32'(rsp_valid), 1);
      check("R10 stalled data", 32'(rsp_data), 32'(e));
      check("R2 ready low in stall", 32'(req_ready), 0);
      check("R2 no strobe in stall", 32'(mem_rd_en), 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R7 latch loaded", latch_word, w);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 mem_rd_en", 32'(mem_rd_en), 0);
    check("R1 latch", latch_word, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 latch after release", latch_word, 0);
    check("R2 idle ready", 32'(req_ready), 1);
    // plane mode sweep
    for (int a = 0; a < 16; a++)
      for (int s = 0; s < 4; s++)
        do_read(16'(a * 37 + 5), 1'b0, 2'(s), 4'(a), 4'(s), (a + s) % 3);
    // match mode sweep
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 16; r++)
        for (int c = 0; c < 16; c++)
          do_read(16'(a * 1111 + 3), 1'b1, 2'(r), 4'(r), 4'(c), ((r + c) % 5 == 0) ? 1 : 0);
    // R8: latch untouched across idle cycles and toggled controls
    keep = latch_word;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cfg_cmp_mode = k[0]; cfg_plane_sel = 2'(k); rsp_ready = k[1];
      req_addr = 16'(k * 91);
      #1;
      check("R2 no strobe when idle", 32'(mem_rd_en), 0);
      check("R8 latch held", latch_word, keep);
    end
    // back-to-back reads with rsp_ready high
    @(negedge clk);
    rsp_ready = 1'b1; req_valid = 1'b1; cfg_cmp_mode = 1'b0; cfg_plane_sel = 2'd2;
    req_addr = 16'd700;
    @(negedge clk);
    check("R3 back-to-back first", 32'(rsp_data), 32'(word_of(16'd700) >> 16) & 32'hFF);
    req_addr = 16'd701;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 back-to-back second", 32'(rsp_data), 32'(word_of(16'd701) >> 16) & 32'hFF);
    check("R7 latch after first", latch_word, word_of(16'd700));
    @(negedge clk);
    check("R7 latch after second", latch_word, word_of(16'd701));
    check("R3 drained", 32'(rsp_valid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule